// File: doc/BRIEF.md
# Match-Register System Tick Timer

This block is a system tick source built on a free-running up-counter. The counter moves forward by one on each cycle where a slow tick enable is high. That enable stands for a low-rate reference somewhere between 32 kHz and 1 MHz. The counter never reloads. It wraps from all ones to zero on its own, and a match never resets it.

The block has several compare channels. Each channel holds a match value. When an increment makes the counter equal to that value, the channel's sticky status bit is set. Software creates periodic interrupts by moving the match value forward from its handler. Each channel drives its own interrupt line, which is the status bit gated by that channel's enable bit.

A debug-halt input freezes the counter while the processor is stopped, so no match can fire during single-stepping. Software reaches the counter, status, enables and match values through a simple register port.

The register port uses a write strobe, an address and write data. Read data is combinational on the address. The address map is:

| Address | Register | Behaviour |
|---|---|---|
| 0 | Counter | Read and write. |
| 1 | Status | Bit i belongs to channel i. Writing 1 to a bit clears it. |
| 2 | Enable | Bit i is channel i's interrupt enable. |
| 3 | Unused | Reads zero. |
| 4 + i | Match value of channel i | Read and write. |

Top module: `stm_tick_timer`

## Requirements
- R1: After reset, the counter, every match value, the status bits, the enable bits and every interrupt line are zero. Address 3 and addresses beyond the last match register read zero.
- R2: On a cycle with tick_en high, halt low and no counter write, the counter advances by one at the next edge. It wraps from 0xFFFFFFFF to 0. With tick_en low it holds.
- R3: While dbg_halt is high the counter does not advance, and no channel's status bit is set by a match.
- R4: A write to address 0 loads the counter at the next edge and wins over an increment in the same cycle. Loading a value equal to a match value does not set that channel's status.
- R5: When an increment produces a counter value equal to the match value of channel i, status bit i (bit i of address 1) is set at the same edge. The counter keeps counting and is not reset.
- R6: A status bit stays set until software writes 1 to that bit at address 1. Writing 0 to a bit has no effect. If a match and a clear of the same bit happen in the same cycle, the bit ends up set.
- R7: irq[i] is high exactly when status bit i and enable bit i (bit i of address 2) are both set. It follows the registers in the same cycle.
- R8: Writing the match register of channel i (address 4 + i) changes only that match value. It leaves status bit i unchanged.
- R9: Channels compare independently, and several may set their status on the same increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable from the slow reference |
| dbg_halt | input | 1 | Freezes the counter while high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational on reg_addr |
| irq | output | N_CH | Per-channel interrupt lines |

## Verification
Each increment, counter load, status set or clear, and register write takes effect at the rising edge that samples the stimulus. Read data and interrupt lines are combinational from the registers, so every result is due one edge after it is applied.

The bench drives inputs on the falling edge and updates its reference model right after the next rising edge. At the following falling edge it sets the read address, waits a short settle time, and then compares the read data and the interrupt lines. Every sample is therefore taken exactly one edge after its cause and away from any active edge.

// File: rtl/stm_pkg.sv
package stm_pkg;
  // Register address map
  localparam int unsigned ADDR_COUNT  = 0;
  localparam int unsigned ADDR_STATUS = 1;
  localparam int unsigned ADDR_ENABLE = 2;
  localparam int unsigned ADDR_MATCH0 = 4;
endpackage

// File: rtl/stm_counter.sv
module stm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             adv
);
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  // An increment only counts when no software load competes with it
  assign adv       = tick_en && !halt && !wr_en;
  assign count_nxt = step_up(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_data;
    else if (adv)   count <= count_nxt;
  end
endmodule

// File: rtl/stm_channel.sv
module stm_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             match_we,
  input  logic [CNT_W-1:0] match_wd,
  input  logic             clr,
  output logic [CNT_W-1:0] match,
  output logic             hit,
  output logic             status
);
  function automatic logic is_hit(input logic a,
                                  input logic [CNT_W-1:0] nv,
                                  input logic [CNT_W-1:0] mv);
    return a && (nv == mv);
  endfunction

  assign hit = is_hit(adv, count_nxt, match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match <= '0;
    else if (match_we) match <= match_wd;
  end

  // Set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= (status && !clr) || hit;
  end
endmodule

// File: rtl/stm_tick_timer.sv
module stm_tick_timer
  import stm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              dbg_halt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int FLAT_W = N_CH * CNT_W;

  logic              cnt_wr;
  logic              adv;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  count_nxt;
  logic [N_CH-1:0]   hit_vec;
  logic [N_CH-1:0]   status_q;
  logic [N_CH-1:0]   enable_q;
  logic [N_CH-1:0]   clr_vec;
  logic [CNT_W-1:0]  match_q [N_CH];
  logic [FLAT_W-1:0] match_flat;

  assign cnt_wr  = reg_we && (reg_addr == ADDR_W'(ADDR_COUNT));
  assign clr_vec = (reg_we && reg_addr == ADDR_W'(ADDR_STATUS)) ? reg_wdata[N_CH-1:0] : '0;

  stm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .halt      (dbg_halt),
    .wr_en     (cnt_wr),
    .wr_data   (reg_wdata),
    .count     (count_q),
    .count_nxt (count_nxt),
    .adv       (adv)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    stm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .count_nxt (count_nxt),
      .match_we  (reg_we && reg_addr == ADDR_W'(ADDR_MATCH0 + g)),
      .match_wd  (reg_wdata),
      .clr       (clr_vec[g]),
      .match     (match_q[g]),
      .hit       (hit_vec[g]),
      .status    (status_q[g])
    );
    assign match_flat[g*CNT_W +: CNT_W] = match_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else if (reg_we && reg_addr == ADDR_W'(ADDR_ENABLE)) enable_q <= reg_wdata[N_CH-1:0];
  end

  assign irq = status_q & enable_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_COUNT))  reg_rdata = count_q;
    if (reg_addr == ADDR_W'(ADDR_STATUS)) reg_rdata[N_CH-1:0] = status_q;
    if (reg_addr == ADDR_W'(ADDR_ENABLE)) reg_rdata[N_CH-1:0] = enable_q;
    for (int i = 0; i < N_CH; i++)
      if (reg_addr == ADDR_W'(ADDR_MATCH0 + i)) reg_rdata = match_q[i];
  end
endmodule

// File: rtl/stm_checker.sv
module stm_checker
  import stm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dbg_halt,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [CNT_W-1:0]       reg_wdata,
  input logic [CNT_W-1:0]       count,
  input logic                   adv,
  input logic                   cnt_wr,
  input logic [N_CH-1:0]        hit,
  input logic [N_CH-1:0]        status,
  input logic [N_CH*CNT_W-1:0]  match_flat
);
  // R2
  cnt_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> count == $past(count) + CNT_W'(1));

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !cnt_wr) |=> $stable(count));

  // R3
  halt_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |-> hit == '0);

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(reg_wdata));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R5
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (count + CNT_W'(1)) == match_flat[i*CNT_W +: CNT_W]) |=> status[i]);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(reg_we && reg_addr == ADDR_W'(ADDR_STATUS) && reg_wdata[i])) |=> status[i]);

    // R5
    status_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(hit[i]));
  end
endmodule

bind stm_tick_timer stm_checker #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_halt   (dbg_halt),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .count      (count_q),
  .adv        (adv),
  .cnt_wr     (cnt_wr),
  .hit        (hit_vec),
  .status     (status_q),
  .match_flat (match_flat)
);

// File: tb/stm_tick_timer_tb_top.sv
`timescale 1ns/1ps
module stm_tick_timer_tb_top;
  localparam int CW = 32;
  localparam int NC = 4;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic tick_en = 0, dbg_halt = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [NC-1:0] irq;

  always #2.5 clk = ~clk;

  stm_tick_timer #(.CNT_W(CW), .N_CH(NC), .ADDR_W(AW)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [CW-1:0] m_cnt;
  logic [CW-1:0] m_match [NC];
  logic [NC-1:0] m_stat, m_en;

  function automatic logic [CW-1:0] model_read(input int a);
    if (a == 0) return m_cnt;
    if (a == 1) return {{(CW-NC){1'b0}}, m_stat};
    if (a == 2) return {{(CW-NC){1'b0}}, m_en};
    if (a >= 4 && a < 4 + NC) return m_match[a-4];
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: check state via raddr, then apply stimulus, then advance model
  task automatic step(input bit te, input bit h, input bit we, input int a,
                      input logic [CW-1:0] d, input int raddr, input string tag);
    logic [NC-1:0] hits;
    logic [NC-1:0] clrm;
    logic inc_ok;
    @(negedge clk);
    reg_we = 0; reg_addr = AW'(raddr);
    #1;
    chk(tag, reg_rdata, model_read(raddr));
    chk("R7", {{(CW-NC){1'b0}}, irq}, {{(CW-NC){1'b0}}, m_stat & m_en});
    tick_en = te; dbg_halt = h; reg_we = we; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk);
    inc_ok = te && !h && !(we && a == 0);
    hits = '0;
    for (int i = 0; i < NC; i++) if (inc_ok && (m_cnt + 1) == m_match[i]) hits[i] = 1'b1;
    clrm = (we && a == 1) ? d[NC-1:0] : '0;
    m_stat = (m_stat & ~clrm) | hits;
    if (we && a == 2) m_en = d[NC-1:0];
    for (int i = 0; i < NC; i++) if (we && a == 4 + i) m_match[i] = d;
    if (we && a == 0) m_cnt = d;
    else if (inc_ok) m_cnt = m_cnt + 1;
  endtask

  task automatic idle(input int raddr, input string tag);
    step(0, 0, 0, 0, '0, raddr, tag);
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    step(0, 0, 1, a, d, 0, "R4");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = '0; m_stat = '0; m_en = '0;
    for (int i = 0; i < NC; i++) m_match[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 10; a++) idle(a, "R1");
    wr(2, 32'hF);
    // R5 R9: two channels share a match value, a third matches later
    wr(4, 32'd5); wr(5, 32'd5); wr(6, 32'd9);
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0, '0, 1, "R9");
    idle(0, "R5"); idle(1, "R5");
    // R2: tick low holds
    step(0, 0, 0, 0, '0, 0, "R2"); idle(0, "R2");
    // R3: halt with match at next value
    wr(7, m_cnt + 1);
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, '0, 1, "R3");
    idle(0, "R3"); idle(1, "R3");
    // R6: write 0 no effect, write 1 clears bit 0
    step(0, 0, 1, 1, 32'h0, 1, "R6"); idle(1, "R6");
    step(0, 0, 1, 1, 32'h1, 1, "R6"); idle(1, "R6");
    // R8: rewriting match 1 keeps status bit 1
    wr(5, 32'd100); idle(1, "R8"); idle(5, "R8");
    // R4: load beats increment, load onto match value does not set status
    wr(1, 32'hF);
    step(1, 0, 1, 0, 32'd9, 0, "R4"); idle(0, "R4"); idle(1, "R4");
    // R2 R5: wrap to zero hits match 0
    wr(4, 32'd0); wr(0, 32'hFFFF_FFFE);
    step(1, 0, 0, 0, '0, 0, "R2"); step(1, 0, 0, 0, '0, 0, "R2");
    idle(0, "R2"); idle(1, "R5");
    // R6: match and clear in same cycle -> set wins
    wr(1, 32'hF); wr(4, m_cnt + 1);
    step(1, 0, 1, 1, 32'h1, 1, "R6"); idle(1, "R6");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 16;
      int a = $urandom % 9;
      bit te = ($urandom % 4) != 0;
      bit h = ($urandom % 10) == 0;
      bit we = r < 5;
      logic [CW-1:0] d;
      if (a >= 4) d = m_cnt + ($urandom % 8);
      else if (a == 0 && ($urandom % 8) == 0) d = 32'hFFFF_FFF0 + ($urandom % 16);
      else if (a == 0) d = m_cnt + ($urandom % 4);
      else d = $urandom;
      step(te, h, we, a, d, $urandom % 9, "R5");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule